// File: doc/BRIEF.md
# LCD Segment Refresh Scanner

This block drives the refresh side of a 64-column dot-matrix segment driver. A 6-bit line counter selects which row of the display memory is shown. The counter is loaded from a start-line value while the frame marker is high, which gives vertical scrolling. It then steps by one on every falling edge of the line clock. Between line-clock edges a fetch engine reads the 64 bytes of the current page through a synchronous read port. It collects the one bit of each byte that belongs to the current row into a shadow line.

On every rising edge of the line clock, the shadow line is copied into the segment latch. A column-order input selects straight or mirrored order for this copy. Each of the 64 segments then gets a 2-bit drive-level code. The code comes from the latched pixel, the alternation input and a display-enable flag that is sampled only at line-clock edges. The line clock, frame marker and alternation input are asynchronous to the system clock and pass through two-flop synchronisers. The analog level generation lies outside this block.

Top module: `lcd_seg_scanner`

## Requirements
- R1: While the synchronised frame marker is high, the line counter holds the start-line value every cycle. After the marker falls, the first row shown is the start line.
- R2: On each rising edge of the line clock, the segment latch takes row Z. Row Z is read from page Z[5:3] at read address {Z[5:3], column[5:0]}, using bit Z[2:0] of each byte. Read data arrives one clock after its address. Each line-clock phase must last at least 70 system clocks.
- R3: On each falling edge of the line clock, with the frame marker low, the line counter increments by one and wraps from 63 to 0.
- R4: With the column-order input high, column c drives segment c, at code bits [2c+1:2c]. With it low, column c drives segment 63-c.
- R5: When the display is on, codes follow from the alternation input and the pixel. Alternation low gives 2'b00 for a lit pixel and 2'b01 for a dark one. Alternation high gives 2'b11 for a lit pixel and 2'b10 for a dark one.
- R6: When the display is off, every segment gives the non-select code for the current alternation level (2'b01 when low, 2'b10 when high), whatever the memory holds.
- R7: A change of the display-enable input has no effect on the segment codes until the next line-clock edge, rising or falling.
- R8: While reset is low, every segment code is 2'b01, the display flag is off and the line counter is 0. The first line latched after reset is row 0.
- R9: If a falling line-clock edge and a high frame marker fall in the same cycle, the preset wins and the counter does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cl_in | input | 1 | Line clock (asynchronous) |
| frm_in | input | 1 | Frame marker (asynchronous) |
| m_in | input | 1 | Drive alternation input (asynchronous) |
| adc_in | input | 1 | Column order: 1 straight, 0 mirrored |
| start_line | input | 6 | Scroll start row |
| disp_on_in | input | 1 | Display enable request |
| ram_rd_addr | output | 9 | Display memory read address {page, column} |
| ram_rd_data | input | 8 | Display memory read data, one clock after address |
| seg_code | output | 128 | Drive-level code, two bits per segment |

## Verification
Two functions can meet in the same cycle: the counter step on a falling line clock and the frame-marker preset. The bench raises the frame marker with one start line, lowers the line clock while the marker is still high, and then releases the marker. The next latched row must be the start line itself, not the row after it. A second pair is the display-enable change and the line-clock edge that applies it. The enable input is toggled well clear of any edge, the codes are checked for no change, and then they are checked again after the next edge.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    LVL_SEL_POS  = 2'b00,
    LVL_NSEL_POS = 2'b01,
    LVL_NSEL_NEG = 2'b10,
    LVL_SEL_NEG  = 2'b11
  } drive_lvl_e;

  function automatic drive_lvl_e pick_level(input logic alt, input logic on, input logic pix);
    drive_lvl_e lvl;
    if (on && pix) lvl = alt ? LVL_SEL_NEG : LVL_SEL_POS;
    else           lvl = alt ? LVL_NSEL_NEG : LVL_NSEL_POS;
    return lvl;
  endfunction

endpackage

// File: rtl/lcd_sync.sv
module lcd_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/lcd_line_fetch.sv
module lcd_line_fetch #(
  parameter int SEGS = 64,
  parameter int ZW   = 6,
  parameter int DW   = 8,
  localparam int COLW = $clog2(SEGS),
  localparam int BITW = $clog2(DW),
  localparam int PGW  = ZW - BITW,
  localparam int AW   = PGW + COLW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ZW-1:0]   row,
  output logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   rd_data,
  output logic [SEGS-1:0] shadow
);
  logic [COLW-1:0] col_q, col_n;
  logic [COLW-1:0] cap_col_q;
  logic [BITW-1:0] cap_bit_q;
  logic            cap_vld_q;
  logic [SEGS-1:0] shadow_q, shadow_n;

  always_comb begin
    if (col_q == COLW'(SEGS - 1)) col_n = '0;
    else                          col_n = col_q + 1'b1;
  end

  always_comb begin
    shadow_n = shadow_q;
    if (cap_vld_q) shadow_n[cap_col_q] = rd_data[cap_bit_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q     <= '0;
      cap_col_q <= '0;
      cap_bit_q <= '0;
      cap_vld_q <= 1'b0;
      shadow_q  <= '0;
    end else begin
      col_q     <= col_n;
      cap_col_q <= col_q;
      cap_bit_q <= row[BITW-1:0];
      cap_vld_q <= 1'b1;
      shadow_q  <= shadow_n;
    end
  end

  assign rd_addr = {row[ZW-1:BITW], col_q};
  assign shadow  = shadow_q;
endmodule

// File: rtl/lcd_seg_encode.sv
module lcd_seg_encode
  import lcd_scan_pkg::*;
#(
  parameter int SEGS = 64
) (
  input  logic [SEGS-1:0]   pix,
  input  logic              alt,
  input  logic              on,
  output logic [2*SEGS-1:0] codes
);
  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    assign codes[2*s +: 2] = pick_level(alt, on, pix[s]);
  end
endmodule

// File: rtl/lcd_seg_scanner.sv
module lcd_seg_scanner
  import lcd_scan_pkg::*;
#(
  parameter int SEGS = 64,
  parameter int ZW   = 6,
  parameter int DW   = 8,
  localparam int BITW = $clog2(DW),
  localparam int AW   = ZW - BITW + $clog2(SEGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cl_in,
  input  logic              frm_in,
  input  logic              m_in,
  input  logic              adc_in,
  input  logic [ZW-1:0]     start_line,
  input  logic              disp_on_in,
  output logic [AW-1:0]     ram_rd_addr,
  input  logic [DW-1:0]     ram_rd_data,
  output logic [2*SEGS-1:0] seg_code
);
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic cl_s, frm_s, m_s;
  lcd_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_ni),
    .d({cl_in, frm_in, m_in}),
    .q({cl_s, frm_s, m_s})
  );

  logic cl_d_q;
  logic cl_rise, cl_fall;
  assign cl_rise = cl_s & ~cl_d_q;
  assign cl_fall = ~cl_s & cl_d_q;

  logic [ZW-1:0] z_q, z_n;
  always_comb begin
    z_n = z_q;
    if (frm_s)        z_n = start_line;
    else if (cl_fall) z_n = z_q + 1'b1;
  end

  logic [SEGS-1:0] shadow;
  lcd_line_fetch #(.SEGS(SEGS), .ZW(ZW), .DW(DW)) u_fetch (
    .clk(clk), .rst_n(rst_ni), .row(z_q),
    .rd_addr(ram_rd_addr), .rd_data(ram_rd_data), .shadow(shadow)
  );

  logic [SEGS-1:0] ordered;
  for (genvar s = 0; s < SEGS; s++) begin : g_order
    assign ordered[s] = adc_in ? shadow[s] : shadow[SEGS-1-s];
  end

  logic [SEGS-1:0] line_q, line_n;
  logic            on_q, on_n;
  always_comb begin
    line_n = line_q;
    on_n   = on_q;
    if (cl_rise)           line_n = ordered;
    if (cl_rise | cl_fall) on_n   = disp_on_in;
  end

  logic [2*SEGS-1:0] codes_n, seg_q;
  lcd_seg_encode #(.SEGS(SEGS)) u_enc (
    .pix(line_q), .alt(m_s), .on(on_q), .codes(codes_n)
  );

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cl_d_q <= 1'b0;
      z_q    <= '0;
      line_q <= '0;
      on_q   <= 1'b0;
      seg_q  <= {SEGS{LVL_NSEL_POS}};
    end else begin
      cl_d_q <= cl_s;
      z_q    <= z_n;
      line_q <= line_n;
      on_q   <= on_n;
      seg_q  <= codes_n;
    end
  end

  assign seg_code = seg_q;
endmodule

// File: rtl/lcd_seg_scanner_chk.sv
module lcd_seg_scanner_chk #(
  parameter int SEGS = 64,
  parameter int ZW   = 6
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              frm_s,
  input logic              cl_rise,
  input logic              cl_fall,
  input logic [ZW-1:0]     z_q,
  input logic [ZW-1:0]     start_line,
  input logic              on_q,
  input logic [2*SEGS-1:0] seg_code
);
  logic [SEGS-1:0] nsel_bits;
  for (genvar s = 0; s < SEGS; s++) begin : g_ns
    assign nsel_bits[s] = seg_code[2*s+1] ^ seg_code[2*s];
  end

  p_preset_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    frm_s |=> (z_q == $past(start_line)));

  p_preset_wins_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (frm_s && cl_fall) |=> (z_q == $past(start_line)));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!frm_s && cl_fall) |=> (z_q == ZW'($past(z_q) + 1'b1)));

  p_hold_z_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (!frm_s && !cl_fall) |=> $stable(z_q));

  p_flag_edge_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    !(cl_rise || cl_fall) |=> $stable(on_q));

  p_off_nsel_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !on_q |=> (&nsel_bits));
endmodule

bind lcd_seg_scanner lcd_seg_scanner_chk #(.SEGS(SEGS), .ZW(ZW)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .frm_s(frm_s), .cl_rise(cl_rise),
  .cl_fall(cl_fall), .z_q(z_q), .start_line(start_line), .on_q(on_q),
  .seg_code(seg_code)
);

// File: tb/lcd_seg_scanner_bench.sv
module lcd_seg_scanner_bench;
  logic         clk;
  logic         rst_n;
  logic         cl_in, frm_in, m_in, adc_in, disp_on_in;
  logic [5:0]   start_line;
  logic [8:0]   ram_rd_addr;
  logic [7:0]   ram_rd_data;
  logic [127:0] seg_code;
  logic [7:0]   mem [0:511];
  int           n_checks;
  int           n_errors;
  bit           done;

  lcd_seg_scanner u_lcd_seg_scanner (
    .clk(clk), .rst_n(rst_n), .cl_in(cl_in), .frm_in(frm_in), .m_in(m_in),
    .adc_in(adc_in), .start_line(start_line), .disp_on_in(disp_on_in),
    .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_rd_data), .seg_code(seg_code)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) ram_rd_data <= mem[ram_rd_addr];

  function automatic logic [127:0] expect_codes(int z, bit adc, bit m, bit on);
    logic [127:0] r;
    for (int s = 0; s < 64; s++) begin
      int  c = adc ? s : 63 - s;
      logic [7:0] b = mem[(z / 8) * 64 + c];
      bit  p = b[z % 8];
      if (on && p) r[2*s +: 2] = m ? 2'b11 : 2'b00;
      else         r[2*s +: 2] = m ? 2'b10 : 2'b01;
    end
    return r;
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic check(string tag, logic [127:0] exp);
    n_checks++;
    if (seg_code !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, seg_code, exp);
    end
  endtask

  task automatic cl_set(logic v);
    cl_in = v;
    wait_clk(100);
  endtask

  task automatic frame_preset(int line);
    start_line = 6'(line);
    frm_in = 1'b1;
    wait_clk(10);
    frm_in = 1'b0;
    wait_clk(100);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    wait_clk(5);
    check("R8 reset codes", {64{2'b01}});
    rst_n = 1'b1;
    wait_clk(100);
    disp_on_in = 1'b1;
    cl_set(1'b1);
    check("R8 first line after reset is row 0", expect_codes(0, 1, 0, 1));
    cl_set(1'b0);
  endtask

  task automatic t_scroll;
    frame_preset(5);
    cl_set(1'b1);
    check("R1 R2 R5 start line shown", expect_codes(5, 1, 0, 1));
    cl_set(1'b0);
    cl_set(1'b1);
    check("R3 next line after fall", expect_codes(6, 1, 0, 1));
    cl_set(1'b0);
    cl_set(1'b1);
    check("R2 page crossing line 7", expect_codes(7, 1, 0, 1));
    cl_set(1'b0);
    cl_set(1'b1);
    check("R2 page crossing line 8", expect_codes(8, 1, 0, 1));
    cl_set(1'b0);
  endtask

  task automatic t_mirror;
    adc_in = 1'b0;
    cl_set(1'b1);
    check("R4 mirrored order", expect_codes(9, 0, 0, 1));
    cl_set(1'b0);
    adc_in = 1'b1;
  endtask

  task automatic t_alt;
    m_in = 1'b1;
    wait_clk(20);
    check("R5 alternation high codes", expect_codes(9, 0, 1, 1));
    m_in = 1'b0;
    wait_clk(20);
  endtask

  task automatic t_off;
    disp_on_in = 1'b0;
    wait_clk(40);
    check("R7 off request held until edge", expect_codes(9, 0, 0, 1));
    cl_set(1'b1);
    check("R6 off codes alt low", {64{2'b01}});
    m_in = 1'b1;
    wait_clk(20);
    check("R6 off codes alt high", {64{2'b10}});
    m_in = 1'b0;
    disp_on_in = 1'b1;
    wait_clk(40);
    check("R7 on request held until edge", {64{2'b01}});
    cl_set(1'b0);
    cl_set(1'b1);
    check("R7 on after edge", expect_codes(11, 1, 0, 1));
    cl_set(1'b0);
  endtask

  task automatic t_wrap;
    frame_preset(63);
    cl_set(1'b1);
    check("R1 line 63 shown", expect_codes(63, 1, 0, 1));
    cl_set(1'b0);
    cl_set(1'b1);
    check("R3 wrap to line 0", expect_codes(0, 1, 0, 1));
    cl_set(1'b0);
  endtask

  task automatic t_collide;
    cl_in = 1'b1;
    wait_clk(100);
    start_line = 6'd20;
    frm_in = 1'b1;
    wait_clk(10);
    cl_in = 1'b0;
    wait_clk(10);
    frm_in = 1'b0;
    wait_clk(100);
    cl_set(1'b1);
    check("R9 preset beats step", expect_codes(20, 1, 0, 1));
    cl_set(1'b0);
  endtask

  task automatic t_reset_mid;
    rst_n = 1'b0;
    wait_clk(3);
    check("R8 reset mid frame", {64{2'b01}});
    rst_n = 1'b1;
    wait_clk(100);
    cl_set(1'b1);
    check("R8 counter zero after reset", expect_codes(0, 1, 0, 1));
    cl_set(1'b0);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    done = 1'b0;
    for (int a = 0; a < 512; a++) mem[a] = 8'((a * 29) ^ (a >> 2) ^ 8'h5A);
    rst_n = 1'b0;
    cl_in = 1'b0;
    frm_in = 1'b0;
    m_in = 1'b0;
    adc_in = 1'b1;
    disp_on_in = 1'b0;
    start_line = 6'd0;
    t_reset;
    t_scroll;
    t_mirror;
    t_alt;
    t_off;
    t_wrap;
    t_collide;
    t_reset_mid;
    done = 1'b1;
    report;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      report;
    end
  end
endmodule